// File: doc/BRIEF.md
# Integer Add/Subtract Flag Unit

This block is the add/subtract slice of an integer execution stage. It takes an operation code, an operand size and two 32-bit operands, and it produces a result and a result-write enable. It also produces a fresh set of six arithmetic flags. The result path is purely combinational. The flags are captured into a register on any clock edge where the valid strobe is high, so the flag state follows the last accepted operation. The incoming carry is a separate input, `carry_i`. It feeds the carry-chained operations and the operations that must preserve carry.

Eight operations are supported: add, add with carry-in, subtract, subtract with borrow-in, increment, decrement, compare and negate. Each one runs at byte, word or doubleword width. Increment, decrement and negate use `dst_i` as their only operand. Compare produces the same flags as subtract but never asks for the result to be written.

The block has no state machine. Its only state is the flag register. That register has two conditions: while `valid_i` is low it holds its value, and while `valid_i` is high it loads a new value. Reset clears it to zero.

Top module: `addsub_flag_unit`

## Requirements
- R1: Op code 0 (add) gives dst+src. The carry flag (flags bit 0) is the carry out of the top bit of the selected size. Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits.
- R2: Op code 1 (add with carry) gives dst+src+carry_i. With carry_i low, the result and flags are identical to op 0.
- R3: Op code 2 (subtract) gives dst-src. The carry flag is set exactly when a borrow leaves the top bit of the selected size.
- R4: Op code 3 (subtract with borrow) gives dst-src-carry_i, and its carry flag is the borrow out.
- R5: Op code 4 (increment, dst+1) and op code 5 (decrement, dst-1) load the carry flag with carry_i unchanged. All other flags are updated.
- R6: Op code 6 (compare) produces the flags of dst-src and holds wr_en_o low.
- R7: Op code 7 (negate) gives 0-dst. Its carry flag is set exactly when dst is nonzero within the selected size.
- R8: The overflow flag (bit 5) is set in two cases. For an add, it is set when the operands have equal signs and the result sign differs. For a subtract, it is set when the operands have different signs and the result sign differs from the minuend's.
- R9: The zero flag (bit 3) and the sign flag (bit 4) look only at the bits of the selected size. result_o bits above that size are zero.
- R10: The parity flag (bit 1) is set when the low 8 result bits hold an even number of ones. The auxiliary flag (bit 2) is the carry or borrow out of bit 3.
- R11: flags_o loads only on a rising clock edge with valid_i high and holds otherwise. Reset clears it to 0. wr_en_o is high only when valid_i is high and the op is not compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand size code |
| dst_i | input | 32 | Destination (first) operand |
| src_i | input | 32 | Source (second) operand |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Result, zero above the selected size |
| wr_en_o | output | 1 | Result write enable |
| flags_o | output | 6 | Registered flags {OF,SF,ZF,AF,PF,CF} |

## Verification
The only internal state is the flag register. A wrong value there shows up on flags_o one clock after the accepted operation. A missed hold shows up after the first idle cycle, because flags_o moves while valid_i is low. A wrong lane choice or a wrong carry input shows up at once on result_o, in the same cycle as the inputs. The bench compares result_o and wr_en_o against its model in the cycle the inputs are applied. It compares flags_o after every clock edge, so any divergence is reported within one cycle.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_INC = 3'd4,
        OP_DEC = 3'd5,
        OP_CMP = 3'd6,
        OP_NEG = 3'd7
    } alu_op_e;

    localparam int FLAG_W  = 6;
    localparam int FL_CF   = 0;
    localparam int FL_PF   = 1;
    localparam int FL_AF   = 2;
    localparam int FL_ZF   = 3;
    localparam int FL_SF   = 4;
    localparam int FL_OF   = 5;
endpackage

// File: rtl/addsub_operand_sel.sv
module addsub_operand_sel
    import addsub_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] src,
    input  logic              carry_in,
    output logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] opb,
    output logic              cin,
    output logic              do_sub,
    output logic              keep_cf
);
    always_comb begin
        opa     = dst;
        opb     = src;
        cin     = 1'b0;
        do_sub  = 1'b0;
        keep_cf = 1'b0;
        unique case (op)
            OP_ADD: ;
            OP_ADC: cin = carry_in;
            OP_SUB: do_sub = 1'b1;
            OP_SBB: begin do_sub = 1'b1; cin = carry_in; end
            OP_INC: begin opb = DATA_W'(1); keep_cf = 1'b1; end
            OP_DEC: begin opb = DATA_W'(1); do_sub = 1'b1; keep_cf = 1'b1; end
            OP_CMP: do_sub = 1'b1;
            OP_NEG: begin opa = '0; opb = dst; do_sub = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/addsub_lane.sv
module addsub_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         do_sub,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] wide;

    always_comb begin
        if (do_sub) wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        else        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        res  = wide[W-1:0];
        cout = wide[W];
        if (do_sub) ovf = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
        else        ovf = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
    end
endmodule

// File: rtl/addsub_flag_gen.sv
module addsub_flag_gen
    import addsub_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res,
    input  logic              lane_cout,
    input  logic              lane_ovf,
    input  logic              lane_sign,
    input  logic              a_bit4,
    input  logic              b_bit4,
    input  logic              keep_cf,
    input  logic              carry_in,
    output logic [FLAG_W-1:0] flags
);
    always_comb begin
        flags         = '0;
        flags[FL_CF]  = keep_cf ? carry_in : lane_cout;
        flags[FL_PF]  = ~^res[7:0];
        flags[FL_AF]  = a_bit4 ^ b_bit4 ^ res[4];
        flags[FL_ZF]  = (res == '0);
        flags[FL_SF]  = lane_sign;
        flags[FL_OF]  = lane_ovf;
    end
endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
    import addsub_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic [2:0]           op_i,
    input  logic [1:0]           size_i,
    input  logic [DATA_W-1:0]    dst_i,
    input  logic [DATA_W-1:0]    src_i,
    input  logic                 carry_i,
    output logic [DATA_W-1:0]    result_o,
    output logic                 wr_en_o,
    output logic [FLAG_W-1:0]    flags_o
);
    localparam int NUM_SIZES = $clog2(DATA_W / BYTE_W) + 1;

    alu_op_e           op;
    logic [DATA_W-1:0] opa, opb;
    logic              cin, do_sub, keep_cf;
    logic [1:0]        sz_idx;
    logic [DATA_W-1:0] lane_res  [NUM_SIZES];
    logic              lane_cout [NUM_SIZES];
    logic              lane_ovf  [NUM_SIZES];
    logic              lane_sign [NUM_SIZES];
    logic [FLAG_W-1:0] flags_next;
    logic [FLAG_W-1:0] flags_q;

    assign op = alu_op_e'(op_i);

    addsub_operand_sel #(.DATA_W(DATA_W)) u_sel (
        .op(op), .dst(dst_i), .src(src_i), .carry_in(carry_i),
        .opa(opa), .opb(opb), .cin(cin), .do_sub(do_sub), .keep_cf(keep_cf)
    );

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_lane
        localparam int W = BYTE_W << k;
        logic [W-1:0] r;
        logic         co, ov;
        addsub_lane #(.W(W)) u_lane (
            .a(opa[W-1:0]), .b(opb[W-1:0]), .cin(cin), .do_sub(do_sub),
            .res(r), .cout(co), .ovf(ov)
        );
        assign lane_res[k]  = DATA_W'(r);
        assign lane_cout[k] = co;
        assign lane_ovf[k]  = ov;
        assign lane_sign[k] = r[W-1];
    end

    always_comb begin
        if (int'(size_i) >= NUM_SIZES) sz_idx = 2'(NUM_SIZES - 1);
        else                           sz_idx = size_i;
    end

    assign result_o = lane_res[sz_idx];
    assign wr_en_o  = valid_i && (op != OP_CMP);

    addsub_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .res(result_o), .lane_cout(lane_cout[sz_idx]), .lane_ovf(lane_ovf[sz_idx]),
        .lane_sign(lane_sign[sz_idx]), .a_bit4(opa[4]), .b_bit4(opb[4]),
        .keep_cf(keep_cf), .carry_in(carry_i), .flags(flags_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flags_q <= '0;
        else if (valid_i) flags_q <= flags_next;
    end

    assign flags_o = flags_q;

    // R5: increment and decrement carry the incoming carry through
    assert_incdec_keep_cf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i == 3'd4 || op_i == 3'd5)) |=> (flags_o[FL_CF] == $past(carry_i)));

    // R6: compare never writes
    assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd6) |-> !wr_en_o);

    // R11: flags hold while idle
    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(flags_o));

    // R9: zero flag follows the result seen at the port
    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (flags_o[FL_ZF] == ($past(result_o) == '0)));

    // R9: nothing above a byte result
    assert_byte_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd0) |-> (result_o[DATA_W-1:BYTE_W] == '0));

    // R10: parity of the low byte
    assert_parity_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (flags_o[FL_PF] == ~^$past(result_o[7:0])));
endmodule

// File: tb/addsub_flag_unit_bench.sv
`timescale 1ns/1ps
module addsub_flag_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] dst_i = '0, src_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [5:0]  flags_o;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    logic [5:0] exp_flags = '0;

    always #2 clk = ~clk;

    addsub_flag_unit u_addsub_flag_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
        .dst_i(dst_i), .src_i(src_i), .carry_i(carry_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    function automatic string tag_of(int op);
        case (op)
            0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
            4, 5: return "R5"; 6: return "R6"; default: return "R7";
        endcase
    endfunction

    // behavioural reference with wide integers
    function automatic void model(input int op, input int sz, input longint d, input longint s,
                                  input bit cf_in, output longint res, output logic [5:0] fo,
                                  output bit we);
        int w = (sz >= 2) ? 32 : (8 << sz);
        longint m = (64'sd1 <<< w) - 1;
        longint half = (m + 1) / 2;
        longint x = d & m, y = s & m, c = 0, full, sx, sy, sfull, nib;
        bit sub = 0;
        int ones = 0;
        case (op)
            1: c = cf_in;
            2: sub = 1;
            3: begin sub = 1; c = cf_in; end
            4: y = 1;
            5: begin y = 1; sub = 1; end
            6: sub = 1;
            7: begin y = x; x = 0; sub = 1; end
            default: ;
        endcase
        full = sub ? x - y - c : x + y + c;
        res  = full & m;
        fo[0] = sub ? (full < 0) : (full > m);
        if (op == 4 || op == 5) fo[0] = cf_in;
        for (int i = 0; i < 8; i++) ones += int'((res >> i) & 1);
        fo[1] = (ones % 2) == 0;
        nib = sub ? (x & 15) - (y & 15) - c : (x & 15) + (y & 15) + c;
        fo[2] = (nib < 0) || (nib > 15);
        fo[3] = (res == 0);
        fo[4] = ((res >> (w - 1)) & 1) != 0;
        sx = (x >= half) ? x - (m + 1) : x;
        sy = (y >= half) ? y - (m + 1) : y;
        sfull = sub ? sx - sy - c : sx + sy + c;
        fo[5] = (sfull > half - 1) || (sfull < -half);
        we = (op != 6);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input bit v, input int op, input int sz, input logic [31:0] d,
                         input logic [31:0] s, input bit cf, input string req);
        longint er; logic [5:0] ef; bit we;
        @(negedge clk);
        valid_i = v; op_i = 3'(op); size_i = 2'(sz); dst_i = d; src_i = s; carry_i = cf;
        model(op, sz, longint'(d), longint'(s), cf, er, ef, we);
        #1;
        check(result_o == 32'(er), req, "result", longint'(result_o), er);
        check(wr_en_o == (v && we), (op == 6) ? "R6" : "R11", "wr_en",
              longint'(wr_en_o), longint'(v && we));
        if (v) exp_flags = ef;
        @(posedge clk); #1;
        check(flags_o == exp_flags, v ? req : "R11", "flags",
              longint'(flags_o), longint'(exp_flags));
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(flags_o == 6'd0, "R11", "reset flags", longint'(flags_o), 0);
        check(wr_en_o == 1'b0, "R11", "reset wr_en", longint'(wr_en_o), 0);
        rst_n = 1'b1;
        // R1 byte carry out, word and dword
        apply(1, 0, 0, 32'h0000_00FF, 32'h0000_0001, 0, "R1");
        apply(1, 0, 1, 32'h0000_8000, 32'h0000_8000, 0, "R1");
        apply(1, 0, 2, 32'hFFFF_FFFF, 32'h0000_0001, 0, "R1");
        // R2 with and without carry
        apply(1, 1, 2, 32'h7FFF_FFFF, 32'h0, 1, "R2");
        apply(1, 1, 0, 32'h12, 32'h34, 0, "R2");
        // R3 borrow, R4 with borrow-in
        apply(1, 2, 0, 32'h00, 32'h01, 0, "R3");
        apply(1, 3, 1, 32'h0005, 32'h0005, 1, "R4");
        // R5 carry kept both ways
        apply(1, 4, 0, 32'hFF, 32'h0, 0, "R5");
        apply(1, 5, 2, 32'h0, 32'h0, 1, "R5");
        // R6 compare equal
        apply(1, 6, 1, 32'h1234, 32'h1234, 0, "R6");
        // R7 negate zero and most negative byte
        apply(1, 7, 0, 32'h0, 32'h0, 1, "R7");
        apply(1, 7, 0, 32'h80, 32'h0, 0, "R7");
        // R8 signed overflow add and subtract
        apply(1, 0, 0, 32'h7F, 32'h01, 0, "R8");
        apply(1, 2, 1, 32'h8000, 32'h0001, 0, "R8");
        // R9 zero over the selected size only, upper bits ignored
        apply(1, 0, 0, 32'hABCD_EF80, 32'h1234_5680, 0, "R9");
        // R10 aux carry and parity
        apply(1, 0, 2, 32'h0F, 32'h01, 0, "R10");
        // R11 idle cycles hold flags
        apply(0, 2, 2, 32'h0, 32'h1, 0, "R11");
        apply(0, 0, 3, 32'h5, 32'h5, 0, "R11");
        // size code 3 behaves as doubleword (R1)
        apply(1, 0, 3, 32'h8000_0000, 32'h8000_0000, 0, "R1");
        for (int i = 0; i < 400; i++) begin
            int op = int'($urandom_range(0, 7));
            apply(($urandom_range(0, 3) != 0), op, int'($urandom_range(0, 3)),
                  $urandom, $urandom, 1'($urandom_range(0, 1)), tag_of(op));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule